// File: doc/BRIEF.md
# Edge-Selectable Input Capture Timer

This block times events on a single external input. A 16-bit counter advances once every time a programmable prescaler divides the clock down. When a chosen transition appears on the capture pin, the block stores the current counter value and raises a sticky pending flag. The same transition can also return the counter to zero, so the stored value then measures the time since the previous such transition.

A 3-bit edge code selects the behaviour. It decides which transitions cause a capture and, separately, which transitions also clear the counter. One group of codes captures on both transitions but clears on only one of them. This lets software read a high time and a full period with no extra logic. The capture pin is asynchronous and is brought into the clock domain inside the block. A run input starts and stops counting and capturing.

Top module: `edge_capture_timer`

## Requirements
- R1: After a synchronous active-low reset, `count_value`, `cap_value` and `cap_pending` are all zero, and the registered edge code is 000.
- R2: The capture pin is resynchronised through two flops. With `psc_limit` = 0, a pin change driven just after clock edge E0 is captured at edge E3. The stored value is the counter value held between E2 and E3, which is the count seen after E0 plus 2.
- R3: Edge codes 000 and 010 capture on rising transitions only. Codes 001 and 011 capture on falling transitions only.
- R4: Edge codes 100, 101, 110 and 111 capture on both rising and falling transitions.
- R5: Codes 010, 101 and 111 clear the counter on a rising transition. Codes 011, 110 and 111 clear it on a falling transition. Codes 000, 001 and 100 never clear it.
- R6: On a transition that both captures and clears, the stored value is the count from before the clear. The counter reads 0 after that edge and then advances at the normal prescaled rate.
- R7: With `run` high, the counter advances by exactly one every `psc_limit`+1 clock cycles.
- R8: `cap_pending` is set by each capture and stays set until a one-cycle `pend_clr` pulse clears it. If a capture happens in the same cycle as `pend_clr`, the flag stays set.
- R9: While `run` is low, the counter and prescaler hold their values. Pin transitions cause no capture and no clear, and they are not replayed when `run` returns high.
- R10: The counter wraps from 16'hFFFF to 0 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Asynchronous capture pin |
| run | input | 1 | Counting and capture enable |
| psc_limit | input | 8 | Prescaler compare value; one count every psc_limit+1 cycles |
| edge_mode | input | 3 | Edge code selecting capture and clear transitions |
| pend_clr | input | 1 | Write-one-to-clear pulse for the pending flag |
| cap_value | output | 16 | Last captured counter value |
| cap_pending | output | 1 | Sticky capture-event flag |
| count_value | output | 16 | Live counter value |

## Verification
A pin change becomes visible to the capture logic two edges after it is driven. The capture register, the pending flag and the counter clear all update on the third edge. The bench therefore drives the pin at a falling clock edge, records the live count at that moment, and samples all outputs at the falling edge after the third rising edge. It expects the recorded count plus 2 for the stored value, and 0 or the recorded count plus 3 for the counter. The prescaler and wrap checks wait whole multiples of the division period, so the expected count does not depend on the prescaler phase.

// File: rtl/cap_pkg.sv
// Package: shared types and the edge-code decoder for the capture timer.
// Assumes the edge code is 3 bits wide; every 3-bit value is meaningful.
package cap_pkg;

    typedef struct packed {
        logic cap_rise;
        logic cap_fall;
        logic clr_rise;
        logic clr_fall;
    } edge_ctl_t;

    // Split an edge code into independent capture and clear enables.
    function automatic edge_ctl_t decode_edge(input logic [2:0] code);
        edge_ctl_t d;
        d.cap_rise = code[2] | ~code[0];
        d.cap_fall = code[2] | code[0];
        d.clr_rise = (code == 3'b010) | (code == 3'b101) | (code == 3'b111);
        d.clr_fall = (code == 3'b011) | (code == 3'b110) | (code == 3'b111);
        return d;
    endfunction

endpackage

// File: rtl/cap_sync.sv
// Module: two-flop synchroniser followed by a rising/falling edge detector.
// Assumes the input is held low during reset; the edge pulses last one cycle.
module cap_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din_async,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, prev_q;

    // Resynchronise the pin and remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= din_async;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Edge pulses come from comparing the current and previous levels.
    always_comb begin
        rise = s2_q & ~prev_q;
        fall = ~s2_q & prev_q;
    end

    // R2
    rise_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(s1_q));
    // R2
    fall_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !$past(s1_q));
endmodule

// File: rtl/cap_prescaler.sv
// Module: clock prescaler that produces a one-cycle tick every LIMIT+1 enabled cycles.
// Assumes the limit is stable while running; a restart returns the phase to zero.
module cap_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_q;

    // A tick is due once the divider count reaches the limit.
    always_comb tick = run & (cnt_q >= limit);

    // Advance the divider while running; hold it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (restart || tick) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
    // R7
    psc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !restart) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/cap_counter.sv
// Module: wrapping up-counter with a synchronous clear.
// Assumes the clear request wins over the increment.
module cap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] val_q;

    // Clear or increment the count while running; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (run) begin
            if (clear)    val_q <= '0;
            else if (inc) val_q <= val_q + 1'b1;
        end
    end

    assign value = val_q;

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(val_q));
    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clear) |=> val_q == '0);
endmodule

// File: rtl/edge_capture_timer.sv
// Module: prescaled 16-bit timer that stores its count on selected pin transitions
// and can clear the counter on a separately selected transition.
// Assumes pin_async is asynchronous; all other inputs are synchronous to clk.
module edge_capture_timer #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic             run,
    input  logic [PSC_W-1:0] psc_limit,
    input  logic [2:0]       edge_mode,
    input  logic             pend_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_pending,
    output logic [CNT_W-1:0] count_value
);
    import cap_pkg::*;

    logic [2:0]       mode_q;
    edge_ctl_t        ctl;
    logic             rise, fall, tick;
    logic             cap_evt, clr_evt;
    logic [CNT_W-1:0] cap_q;
    logic             pend_q;

    // Register the edge code so that it starts at 000 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 3'b000;
        else        mode_q <= edge_mode;
    end

    cap_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_async (pin_async),
        .rise      (rise),
        .fall      (fall)
    );

    // Combine the detected edges with the decoded code into capture and clear events.
    always_comb begin
        ctl     = decode_edge(mode_q);
        cap_evt = run & ((rise & ctl.cap_rise) | (fall & ctl.cap_fall));
        clr_evt = run & ((rise & ctl.clr_rise) | (fall & ctl.clr_fall));
    end

    cap_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (clr_evt),
        .limit   (psc_limit),
        .tick    (tick)
    );

    cap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (clr_evt),
        .inc   (tick),
        .value (count_value)
    );

    // Store the pre-clear count on a capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= count_value;
    end

    // Keep the pending flag sticky; a new capture wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (cap_evt)  pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

    assign cap_value   = cap_q;
    assign cap_pending = pend_q;

    // R9
    no_capture_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(run));
    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !cap_evt) |=> !pend_q);
    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> pend_q);
    // R6
    cap_precount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_q == $past(count_value));
endmodule

// File: tb/tb_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_edge_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_async = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  psc_limit = 8'd0;
    logic [2:0]  edge_mode = 3'b000;
    logic        pend_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_pending;
    logic [15:0] count_value;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    edge_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .run(run),
        .psc_limit(psc_limit), .edge_mode(edge_mode), .pend_clr(pend_clr),
        .cap_value(cap_value), .cap_pending(cap_pending), .count_value(count_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_pending();
        pend_clr = 1'b1;
        cycles(1);
        pend_clr = 1'b0;
    endtask

    // Drive one transition in a given code and check capture, flag and counter (R2-R6).
    task automatic edge_trial(input logic [2:0] code, input logic dir);
        logic [15:0] c0, prev_cap;
        logic exp_cap, exp_clr;
        edge_mode = code;
        cycles(3);
        clear_pending();
        check("R8 cleared", cap_pending, 0);
        exp_cap = code[2] || (dir ? (code[0] == 1'b0) : (code[0] == 1'b1));
        case (code)
            3'b010, 3'b101: exp_clr = dir;
            3'b011, 3'b110: exp_clr = !dir;
            3'b111:         exp_clr = 1'b1;
            default:        exp_clr = 1'b0;
        endcase
        prev_cap = cap_value;
        c0 = count_value;
        pin_async = dir;
        cycles(3);
        check(exp_cap ? (code[2] ? "R4 capture value" : "R3 capture value") : "R3 no capture",
              cap_value, exp_cap ? c0 + 16'd2 : prev_cap);
        check("R8 pending", cap_pending, exp_cap);
        check(exp_clr ? "R6 counter cleared" : "R5 counter kept",
              count_value, exp_clr ? 16'd0 : c0 + 16'd3);
        if (exp_clr) begin
            cycles(2);
            check("R6 restart", count_value, 16'd2);
        end
    endtask

    initial begin
        logic [15:0] c0;
        cycles(3);
        check("R1 count", count_value, 0);
        check("R1 capture", cap_value, 0);
        check("R1 pending", cap_pending, 0);
        rst_n = 1'b1;
        run = 1'b1;
        cycles(2);

        // Sweep every code with both transitions (R2-R6, R8).
        for (int m = 0; m < 8; m++) begin
            edge_trial(m[2:0], 1'b1);
            edge_trial(m[2:0], 1'b0);
        end

        // Capture in the same cycle as a clear pulse keeps the flag (R8).
        edge_mode = 3'b100;
        cycles(3);
        clear_pending();
        pin_async = 1'b1;
        cycles(2);
        pend_clr = 1'b1;
        cycles(1);
        pend_clr = 1'b0;
        check("R8 capture beats clear", cap_pending, 1);
        cycles(2);
        clear_pending();

        // Prescaler rate over whole periods (R7).
        for (int p = 0; p < 6; p++) begin
            psc_limit = p[7:0];
            cycles(8);
            c0 = count_value;
            cycles(3 * (p + 1));
            check("R7 prescale rate", count_value, c0 + 16'd3);
        end
        psc_limit = 8'd0;
        cycles(2);

        // Stopped: hold, ignore edges, no replay (R9).
        clear_pending();
        run = 1'b0;
        cycles(1);
        c0 = count_value;
        pin_async = 1'b0;
        cycles(4);
        pin_async = 1'b1;
        cycles(4);
        check("R9 count held", count_value, c0);
        check("R9 no capture", cap_pending, 0);
        run = 1'b1;
        cycles(4);
        check("R9 no replay", cap_pending, 0);
        check("R9 resumes", count_value, c0 + 16'd4);

        // Wrap past all ones (R10).
        c0 = count_value;
        cycles(65536 - int'(c0) + 5);
        check("R10 wrap", count_value, 16'd5);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule